// File: doc/BRIEF.md
# Serial RS(15,11) Systematic Encoder

This block turns a stream of 4-bit message symbols into Reed-Solomon codewords over GF(16). A producer presents eleven message symbols, one per accepted clock, and marks the first with a start-of-block flag. Each accepted symbol is copied to the output one cycle later. After the eleventh, the block emits four check symbols on four back-to-back cycles. A checker that divides a received 15-symbol word by the same generator gets a zero remainder. The resulting code has minimum distance 5, so a decoder can repair any two corrupted symbols in a word.

Internally, a four-stage feedback shift register divides the shifted message polynomial by the generator g(x) = x^4 + 15x^3 + 3x^2 + x + 12. Field products use the primitive polynomial x^4 + x + 1, where alpha is 2. While message symbols arrive, the feedback path is open and the output multiplexer selects the input. In the check phase, the feedback is forced to zero, so the register chain shifts the remainder out through the multiplexer. The block takes a new codeword every 15 cycles with no dead cycle.

Top module: `rs15_11_enc`

## Requirements
- R1: While reset is asserted, and until a block is accepted after it, `out_valid`, `out_sob` and `out_last` are low.
- R2: A message symbol accepted on a clock edge (`in_valid` high) appears on `out_sym` with `out_valid` high in the cycle that follows that edge.
- R3: In the four cycles after the eleventh message symbol is output, `out_valid` is high and `out_sym` carries the remainder of m(x)*x^4 divided by g(x) = x^4 + 15x^3 + 3x^2 + x + 12 over GF(16) with primitive polynomial x^4 + x + 1. The coefficient of x^3 comes first and the coefficient of x^0 comes last. The first accepted symbol is the coefficient of x^10 of m(x).
- R4: `out_last` is high only with the fourth check symbol.
- R5: `out_sob` is high only with the output copy of a symbol that was accepted with `in_sob` high.
- R6: When no block is open, a symbol presented with `in_valid` high but `in_sob` low is ignored and produces no output.
- R7: During the message phase, a cycle with `in_valid` low accepts nothing and produces no output; the block continues with the next valid symbol.
- R8: Inputs are ignored in the four cycles that start with the output of the eleventh message symbol and end with the output of the third check symbol. This holds even when `in_valid` and `in_sob` are both high.
- R9: A symbol with `in_sob` high during the message phase discards the partial block and starts a new block with that symbol.
- R10: A start-of-block symbol presented in the cycle in which `out_last` is high is accepted, so codewords can follow each other every 15 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input symbol is present |
| in_sob | input | 1 | Input symbol is the first of a block |
| in_sym | input | 4 | Message symbol |
| out_valid | output | 1 | Output symbol is present |
| out_sym | output | 4 | Codeword symbol, either the message copy or a check symbol |
| out_sob | output | 1 | Output symbol is the first of a codeword |
| out_last | output | 1 | Output symbol is the last of a codeword |

## Verification
Every output is registered exactly once, so the copy of a message symbol accepted on one edge shows up in the cycle that follows that edge. The first check symbol follows the copy of the eleventh message symbol in the next cycle, and the other three follow on consecutive cycles. The driver queues each expected symbol, with its flags, as it presents the input. The monitor samples only on the falling edge and pops one entry for each cycle in which `out_valid` is high. Any gap that appears, any extra symbol or any missing symbol shifts the stream and shows up as a mismatch. Check values come from long division using log and antilog tables built in the bench.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 4;
  localparam int N_SYM = 15;
  localparam int K_SYM = 11;
  localparam int NPAR  = N_SYM - K_SYM;

  // low taps of the primitive polynomial x^4 + x + 1
  localparam logic [SYM_W-1:0] PRIM_TAPS = 4'h3;

  // generator coefficients, lane i holds the coefficient of x^i (monic term implied)
  localparam logic [NPAR*SYM_W-1:0] GEN_COEF = {4'd15, 4'd3, 4'd1, 4'd12};

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAR  = 2'd2
  } phase_t;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ PRIM_TAPS) : (sh << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter logic [SYM_W-1:0] COEF = '0
) (
  input  logic [SYM_W-1:0] a,
  output logic [SYM_W-1:0] y
);
  always_comb y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int K  = K_SYM,
  parameter int NP = NPAR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sob,
  output logic accept,
  output logic restart,
  output logic par_step,
  output logic last_par,
  output logic msg_phase
);
  localparam int CW = $clog2(K + 1);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;

  phase_t        phase_q, phase_d;
  logic [CW-1:0] msg_cnt_q, msg_cnt_d;
  logic [PW-1:0] par_cnt_q, par_cnt_d;
  logic          par_en;

  always_comb begin
    phase_d   = phase_q;
    msg_cnt_d = msg_cnt_q;
    par_cnt_d = par_cnt_q;
    accept    = 1'b0;
    restart   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (in_valid && in_sob) begin
          accept    = 1'b1;
          restart   = 1'b1;
          msg_cnt_d = CW'(1);
          phase_d   = PH_MSG;
        end
      end
      PH_MSG: begin
        if (in_valid) begin
          accept  = 1'b1;
          restart = in_sob;
          if (in_sob) begin
            msg_cnt_d = CW'(1);
          end else begin
            msg_cnt_d = msg_cnt_q + 1'b1;
            if (msg_cnt_q == CW'(K - 1)) begin
              phase_d   = PH_PAR;
              par_cnt_d = '0;
            end
          end
        end
      end
      PH_PAR: begin
        par_cnt_d = par_cnt_q + 1'b1;
        if (par_cnt_q == PW'(NP - 1)) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    par_step  = (phase_q == PH_PAR);
    last_par  = par_step && (par_cnt_q == PW'(NP - 1));
    msg_phase = (phase_q == PH_MSG);
    par_en    = par_step || (phase_d == PH_PAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      msg_cnt_q <= '0;
      par_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) msg_cnt_q <= msg_cnt_d;
      if (par_en) par_cnt_q <= par_cnt_d;
    end
  end
endmodule

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NP = NPAR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             restart,
  input  logic             fb_off,
  input  logic [SYM_W-1:0] in_sym,
  output logic [SYM_W-1:0] par_sym
);
  logic [NP-1:0][SYM_W-1:0] rem_q;
  logic [NP-1:0][SYM_W-1:0] rem_d;
  logic [NP-1:0][SYM_W-1:0] prod;
  logic [SYM_W-1:0]         fb;

  always_comb begin
    if (fb_off) fb = '0;
    else        fb = in_sym ^ (restart ? '0 : rem_q[NP-1]);
  end

  for (genvar g = 0; g < NP; g++) begin : g_stage
    rs_gf_cmul #(.COEF(GEN_COEF[g*SYM_W +: SYM_W])) u_mul (
      .a(fb),
      .y(prod[g])
    );
    if (g == 0) begin : g_first
      always_comb rem_d[g] = prod[g];
    end else begin : g_rest
      always_comb rem_d[g] = (restart ? '0 : rem_q[g-1]) ^ prod[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem_q[g] <= '0;
      else if (load) rem_q[g] <= rem_d[g];
    end
  end

  always_comb par_sym = rem_q[NP-1];
endmodule

// File: rtl/rs_enc_out.sv
module rs_enc_out
  import rs_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic             par_step,
  input  logic             last_par,
  input  logic [SYM_W-1:0] in_sym,
  input  logic [SYM_W-1:0] par_sym,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_sob,
  output logic             out_last
);
  logic             vld_d;
  logic [SYM_W-1:0] sym_d;

  always_comb begin
    vld_d = accept || par_step;
    sym_d = par_step ? par_sym : in_sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_last  <= 1'b0;
      out_sym   <= '0;
    end else begin
      out_valid <= vld_d;
      out_sob   <= accept && restart;
      out_last  <= last_par;
      if (vld_d) out_sym <= sym_d;
    end
  end
endmodule

// File: rtl/rs15_11_enc.sv
module rs15_11_enc
  import rs_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sob,
  input  logic [SYM_W-1:0] in_sym,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_sob,
  output logic             out_last
);
  logic       rst_s;
  logic [1:0] rst_pipe;
  logic       accept, restart, par_step, last_par, msg_phase;
  logic [SYM_W-1:0] par_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  always_comb rst_s = rst_pipe[1];

  rs_enc_ctrl #(.K(K_SYM), .NP(NPAR)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .in_sob(in_sob),
    .accept(accept), .restart(restart), .par_step(par_step),
    .last_par(last_par), .msg_phase(msg_phase)
  );

  rs_enc_lfsr #(.NP(NPAR)) u_lfsr (
    .clk(clk), .rst_n(rst_s), .load(accept || par_step), .restart(restart),
    .fb_off(par_step), .in_sym(in_sym), .par_sym(par_sym)
  );

  rs_enc_out u_out (
    .clk(clk), .rst_n(rst_s), .accept(accept), .restart(restart),
    .par_step(par_step), .last_par(last_par), .in_sym(in_sym),
    .par_sym(par_sym), .out_valid(out_valid), .out_sym(out_sym),
    .out_sob(out_sob), .out_last(out_last)
  );
endmodule

// File: rtl/rs_enc_chk.sv
module rs_enc_chk
  import rs_enc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sob,
  input logic [SYM_W-1:0] in_sym,
  input logic             accept,
  input logic             par_step,
  input logic             msg_phase,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_sym,
  input logic             out_sob,
  input logic             out_last
);
  // R1
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      reset_quiet_chk: assert (!out_valid && !out_sob && !out_last)
        else $error("outputs active during reset");
    end
  end

  // R2
  msg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && (out_sym == $past(in_sym)) && !out_last);

  // R3
  par_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_step |=> out_valid && !out_sob);

  // R4
  last_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && $past(par_step) && $past(par_step, 2) && $past(par_step, 3));

  // R5
  sob_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sob |-> out_valid && $past(in_valid && in_sob));

  // R6
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_sob) |-> msg_phase);

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !accept);

  // R8
  par_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_step |-> !accept);

  // R10
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !par_step && !msg_phase);
endmodule

bind rs15_11_enc rs_enc_chk u_chk (
  .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .in_sob(in_sob),
  .in_sym(in_sym), .accept(accept), .par_step(par_step),
  .msg_phase(msg_phase), .out_valid(out_valid), .out_sym(out_sym),
  .out_sob(out_sob), .out_last(out_last)
);

// File: tb/sim_rs15_11_enc.sv
`timescale 1ns/1ps
module sim_rs15_11_enc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sob;
  logic [3:0] in_sym;
  logic       out_valid, out_sob, out_last;
  logic [3:0] out_sym;

  typedef struct {
    logic [3:0] sym;
    logic       sob;
    logic       last;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  bit   mon_on = 1'b0;
  int   gexp[15];
  int   glog[16];

  always #2 clk = ~clk;

  rs15_11_enc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
    .in_sym(in_sym), .out_valid(out_valid), .out_sym(out_sym),
    .out_sob(out_sob), .out_last(out_last)
  );

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  // long division of m(x)*x^4 by g(x); returns {c3,c2,c1,c0}
  function automatic logic [15:0] ref_parity(logic [43:0] msg);
    int c[15];
    int gf[5] = '{12, 1, 3, 15, 1};
    for (int i = 0; i < 15; i++) c[i] = 0;
    for (int i = 0; i < 11; i++) c[14-i] = int'(msg[i*4 +: 4]);
    for (int d = 14; d >= 4; d--) begin
      int co = c[d];
      for (int j = 0; j < 5; j++) c[d-4+j] = c[d-4+j] ^ fmul(co, gf[j]);
    end
    return {c[3][3:0], c[2][3:0], c[1][3:0], c[0][3:0]};
  endfunction

  task automatic drive(input logic v, input logic s, input logic [3:0] d);
    @(negedge clk);
    in_valid = v;
    in_sob   = s;
    in_sym   = d;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // sends one block; parity-phase cycles filled with junk when junk=1 (R8)
  task automatic send_block(input logic [43:0] msg, input bit gaps, input bit junk, input string btag);
    logic [15:0] p;
    for (int i = 0; i < 11; i++) begin
      if (gaps && (i % 3 == 1)) drive(1'b0, 1'b1, 4'($urandom)); // R7 gap cycle
      drive(1'b1, i == 0, msg[i*4 +: 4]);
      q.push_back('{msg[i*4 +: 4], i == 0, 1'b0, {(i == 0) ? "R5" : "R2", "/", btag}});
    end
    p = ref_parity(msg);
    for (int k = 3; k >= 0; k--)
      q.push_back('{p[k*4 +: 4], 1'b0, k == 0, {(k == 0) ? "R4" : "R3", "/", btag}});
    for (int k = 0; k < 4; k++) begin
      if (junk) drive(1'b1, 1'b1, 4'($urandom)); // R8
      else      drive(1'b0, 1'b0, 4'h0);
    end
  endtask

  function automatic logic [43:0] rand_msg();
    logic [43:0] m;
    for (int i = 0; i < 11; i++) m[i*4 +: 4] = 4'($urandom);
    return m;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && out_valid === 1'b1) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R6: unexpected output sym=%h actual, expected none", out_sym);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_sym !== e.sym || out_sob !== e.sob || out_last !== e.last) begin
          n_fail++;
          $display("FAIL %s: actual sym=%h sob=%b last=%b expected sym=%h sob=%b last=%b",
                   e.tag, out_sym, out_sob, out_last, e.sym, e.sob, e.last);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [43:0] m;
    int v = 1;
    for (int i = 0; i < 15; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v << 1;
      if (v & 16) v = (v ^ 16) ^ 3;
    end
    glog[0] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_sym = 4'h0;
    repeat (5) @(negedge clk);
    check("R1", {3'b0, out_valid}, 4'h0);
    check("R1", {3'b0, out_sob}, 4'h0);
    check("R1", {3'b0, out_last}, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {3'b0, out_valid}, 4'h0);
    mon_on = 1'b1;

    // R6: valid without start while idle
    drive(1'b1, 1'b0, 4'h9);
    drive(1'b1, 1'b0, 4'h5);
    drive(1'b0, 1'b0, 4'h0);
    check("R6", {3'b0, out_valid}, 4'h0);
    @(negedge clk);
    check("R6", {3'b0, out_valid}, 4'h0);

    send_block(44'h0, 1'b0, 1'b0, "zero");
    send_block(44'h1, 1'b0, 1'b0, "unit");
    send_block({4'h1, 40'h0}, 1'b0, 1'b0, "tail");
    send_block(44'hFFFFFFFFFFF, 1'b0, 1'b1, "R8");
    for (int b = 0; b < 6; b++) send_block(rand_msg(), 1'b0, b[0], "R10");
    send_block(rand_msg(), 1'b1, 1'b0, "R7");

    // R9: partial block, then restart
    m = rand_msg();
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, i == 0, m[i*4 +: 4]);
      q.push_back('{m[i*4 +: 4], i == 0, 1'b0, (i == 0) ? "R5/R9" : "R2/R9"});
    end
    send_block(rand_msg(), 1'b0, 1'b0, "R9");
    for (int b = 0; b < 4; b++) send_block(rand_msg(), b[1], 1'b1, "R10");

    drive(1'b0, 1'b0, 4'h0);
    repeat (20) @(negedge clk);
    check("R3", 4'(q.size()), 4'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule